// File: doc/BRIEF.md
# Configuration Port Controller

This block sits on a simple byte-wide I/O bus and gives the host a two-address window into a set of configuration registers. A write to the lower address of the pair chooses a register index. The upper address then reads or writes the register that the index names. The window is shut after reset. Two consecutive unlock key writes to the index address open it, and a separate lock key shuts it again.

While the window is open, a few indices reach global registers. These are a logical-device selector plus read-only chip identity and revision bytes, and they answer whichever device is selected. Every other index goes to the logical device that the selector names. The block forwards the index, the write data and one-cycle read and write strobes to that device, and returns the device's read byte to the host. Function 6 is the general-purpose I/O device. A strap input places the port pair at one of two base addresses.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the window is locked and the device selector holds 0x00. While locked, a read of either port returns 0xFF.
- R2: The index port is at the base address and the data port at base+1. The base is BASE_A (0x2E) with `strap_alt` low and BASE_B (0x4E) with it high. Accesses to any other address produce no `io_rvalid` and no device strobe.
- R3: The window opens only after two index-port writes of UNLOCK_KEY (0x87) in a row. Any other index-port write restarts the sequence. The key writes do not load the index register.
- R4: While locked, data-port writes change no register and raise no device strobe.
- R5: An index-port write of LOCK_KEY (0xAA) while open locks the window and leaves the index register unchanged.
- R6: While open, an index-port write of any value other than LOCK_KEY loads the index register. An index-port read returns the index register.
- R7: Index 0x07 is the device selector. A data write stores the byte and a data read returns it.
- R8: Index 0x20 and index 0x21 return CHIP_ID high and low bytes. Index 0x22 returns CHIP_REV. Index 0x23 and index 0x24 return 0x19 and 0x34. Data writes to these indices have no effect. Other indices below 0x30 read 0xFF.
- R9: A data-port write with index at or above 0x30 pulses `ld_wr[sel]` in the same cycle, with `ld_index` equal to the index and `ld_wdata` equal to the byte. No other bit of `ld_wr` rises.
- R10: A data-port read with index at or above 0x30 pulses `ld_rd[sel]` in the same cycle. The read returns byte `sel` of `ld_rdata`, which is bits sel*8+7 down to sel*8.
- R11: When the selector is NUM_LD (8) or above, forwarded accesses raise no strobe and reads return 0xFF.
- R12: Indices below 0x30 never raise a device strobe, whatever the selector holds.
- R13: `io_rvalid` is high exactly one cycle after an `io_rd` that hits either port, and `io_rdata` carries the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base address select: 0 for BASE_A, 1 for BASE_B |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Bus write strobe |
| io_rd | input | 1 | Bus read strobe |
| io_wdata | input | 8 | Bus write byte |
| io_rdata | output | 8 | Read result, valid with io_rvalid |
| io_rvalid | output | 1 | Read result valid |
| ld_index | output | 8 | Current index as seen by logical devices |
| ld_wdata | output | 8 | Write byte for logical devices |
| ld_wr | output | NUM_LD | One-hot device write strobe |
| ld_rd | output | NUM_LD | One-hot device read strobe |
| ld_rdata | input | NUM_LD*8 | Read bytes from all logical devices |

## Verification
The bench breaks the key sequence with a foreign index write between two unlock keys. A controller that only counts key writes would open the window early, and the next data read would return something other than 0xFF. It selects a device number past the last device, where a bad range check would strobe or return a wrapped-around device. It writes to a global index while a device is selected, where faulty steering would strobe that device. It also moves the strap and reaches the ports at the other base, where the old addresses must go silent. Finally, it locks and reopens the window and reads the index back, which catches a lock key that wrongly overwrites the index.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] IDX_DEV_SELECT = 8'h07;
   localparam logic [7:0] IDX_CHIP_HI    = 8'h20;
   localparam logic [7:0] IDX_CHIP_LO    = 8'h21;
   localparam logic [7:0] IDX_CHIP_REV   = 8'h22;
   localparam logic [7:0] IDX_VEND_HI    = 8'h23;
   localparam logic [7:0] IDX_VEND_LO    = 8'h24;
   localparam logic [7:0] IDX_DEV_FIRST  = 8'h30;
   localparam logic [7:0] FILL_BYTE      = 8'hFF;

   function automatic logic is_global(input logic [7:0] idx);
      return idx < IDX_DEV_FIRST;
   endfunction

endpackage

// File: rtl/cfgport_addr_dec.sv
module cfgport_addr_dec #(
   parameter int unsigned ADDR_W = 16,
   parameter bit          DUAL_BASE = 1'b1,
   parameter logic [ADDR_W-1:0] BASE_A = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_B = 'h4E
) (
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              hit_idx,
   output logic              hit_dat
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (ADDR_W < 8) begin : g_bad_width
      $error("cfgport_addr_dec: ADDR_W must be at least 8");
   end
   if (BASE_A[0] != 1'b0 || BASE_B[0] != 1'b0) begin : g_bad_base
      $error("cfgport_addr_dec: base addresses must be even");
   end

   logic [ADDR_W-1:0] base_now;

   if (DUAL_BASE) begin : g_dual
      assign base_now = strap_alt ? BASE_B : BASE_A;
   end else begin : g_single
      logic unused_strap;
      assign unused_strap = strap_alt;
      assign base_now = BASE_A;
   end

   assign hit_idx = (io_addr == base_now);
   assign hit_dat = (io_addr == (base_now + ONE));

endmodule

// File: rtl/cfgport_key_seq.sv
module cfgport_key_seq
   import cfgport_pkg::*;
#(
   parameter logic [7:0] UNLOCK_KEY = 8'h87,
   parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open
);
   if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_keys
      $error("cfgport_key_seq: lock and unlock keys must differ");
   end

   key_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (idx_wr) begin
         unique case (st_q)
            KS_LOCKED: st_d = (wdata == UNLOCK_KEY) ? KS_HALF : KS_LOCKED;
            KS_HALF:   st_d = (wdata == UNLOCK_KEY) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   st_d = (wdata == LOCK_KEY)   ? KS_LOCKED : KS_OPEN;
            default:   st_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign open = (st_q == KS_OPEN);

endmodule

// File: rtl/cfgport_global_regs.sv
module cfgport_global_regs
   import cfgport_pkg::*;
#(
   parameter logic [7:0]  LOCK_KEY = 8'hAA,
   parameter logic [15:0] CHIP_ID  = 16'h0814,
   parameter logic [7:0]  CHIP_REV = 8'h05,
   parameter logic [15:0] VEND_ID  = 16'h1934
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       open,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wdata,
   output logic [7:0] cur_idx,
   output logic [7:0] cur_ldn,
   output logic       glob_sel,
   output logic [7:0] glob_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx <= 8'h00;
         cur_ldn <= 8'h00;
      end else if (open) begin
         if (idx_wr && wdata != LOCK_KEY) cur_idx <= wdata;
         if (dat_wr && cur_idx == IDX_DEV_SELECT) cur_ldn <= wdata;
      end
   end

   assign glob_sel = is_global(cur_idx);

   always_comb begin
      unique case (cur_idx)
         IDX_DEV_SELECT: glob_rdata = cur_ldn;
         IDX_CHIP_HI:    glob_rdata = CHIP_ID[15:8];
         IDX_CHIP_LO:    glob_rdata = CHIP_ID[7:0];
         IDX_CHIP_REV:   glob_rdata = CHIP_REV;
         IDX_VEND_HI:    glob_rdata = VEND_ID[15:8];
         IDX_VEND_LO:    glob_rdata = VEND_ID[7:0];
         default:        glob_rdata = FILL_BYTE;
      endcase
   end

endmodule

// File: rtl/cfgport_ld_route.sv
module cfgport_ld_route
   import cfgport_pkg::*;
#(
   parameter int unsigned NUM_LD = 8
) (
   input  logic              open,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic              glob_sel,
   input  logic [7:0]        cur_ldn,
   input  logic [NUM_LD*8-1:0] ld_rdata,
   output logic [NUM_LD-1:0] ld_wr,
   output logic [NUM_LD-1:0] ld_rd,
   output logic [7:0]        dev_rdata
);
   localparam logic [8:0] LD_COUNT = 9'(NUM_LD);

   if (NUM_LD < 1 || NUM_LD > 256) begin : g_bad_count
      $error("cfgport_ld_route: NUM_LD must be 1..256");
   end

   logic fwd_ok, fwd_wr, fwd_rd;
   assign fwd_ok = open && !glob_sel && ({1'b0, cur_ldn} < LD_COUNT);
   assign fwd_wr = fwd_ok && dat_wr;
   assign fwd_rd = fwd_ok && dat_rd;

   for (genvar k = 0; k < NUM_LD; k++) begin : g_dev
      logic hit;
      assign hit      = (cur_ldn == 8'(k));
      assign ld_wr[k] = fwd_wr && hit;
      assign ld_rd[k] = fwd_rd && hit;
   end

   always_comb begin
      dev_rdata = FILL_BYTE;
      for (int k = 0; k < NUM_LD; k++) begin
         if (cur_ldn == 8'(k)) dev_rdata = ld_rdata[k*8 +: 8];
      end
   end

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned NUM_LD     = 8,
   parameter bit          DUAL_BASE  = 1'b1,
   parameter logic [ADDR_W-1:0] BASE_A = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_B = 'h4E,
   parameter logic [7:0]  UNLOCK_KEY = 8'h87,
   parameter logic [7:0]  LOCK_KEY   = 8'hAA,
   parameter logic [15:0] CHIP_ID    = 16'h0814,
   parameter logic [7:0]  CHIP_REV   = 8'h05,
   parameter logic [15:0] VEND_ID    = 16'h1934
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strap_alt,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic                io_rd,
   input  logic [7:0]          io_wdata,
   output logic [7:0]          io_rdata,
   output logic                io_rvalid,
   output logic [7:0]          ld_index,
   output logic [7:0]          ld_wdata,
   output logic [NUM_LD-1:0]   ld_wr,
   output logic [NUM_LD-1:0]   ld_rd,
   input  logic [NUM_LD*8-1:0] ld_rdata
);
   logic       hit_idx, hit_dat;
   logic       lk_open;
   logic [7:0] cur_idx, cur_ldn;
   logic       glob_sel;
   logic [7:0] glob_rdata, dev_rdata, rd_next;
   logic       idx_wr, dat_wr, dat_rd, any_rd;

   cfgport_addr_dec #(
      .ADDR_W(ADDR_W), .DUAL_BASE(DUAL_BASE), .BASE_A(BASE_A), .BASE_B(BASE_B)
   ) dec_i (
      .strap_alt(strap_alt), .io_addr(io_addr),
      .hit_idx(hit_idx), .hit_dat(hit_dat)
   );

   assign idx_wr = io_wr && hit_idx;
   assign dat_wr = io_wr && hit_dat;
   assign dat_rd = io_rd && hit_dat;
   assign any_rd = io_rd && (hit_idx || hit_dat);

   cfgport_key_seq #(.UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) key_i (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata), .open(lk_open)
   );

   cfgport_global_regs #(
      .LOCK_KEY(LOCK_KEY), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .VEND_ID(VEND_ID)
   ) glob_i (
      .clk(clk), .rst_n(rst_n), .open(lk_open), .idx_wr(idx_wr), .dat_wr(dat_wr),
      .wdata(io_wdata), .cur_idx(cur_idx), .cur_ldn(cur_ldn),
      .glob_sel(glob_sel), .glob_rdata(glob_rdata)
   );

   cfgport_ld_route #(.NUM_LD(NUM_LD)) route_i (
      .open(lk_open), .dat_wr(dat_wr), .dat_rd(dat_rd), .glob_sel(glob_sel),
      .cur_ldn(cur_ldn), .ld_rdata(ld_rdata),
      .ld_wr(ld_wr), .ld_rd(ld_rd), .dev_rdata(dev_rdata)
   );

   assign ld_index = cur_idx;
   assign ld_wdata = io_wdata;

   always_comb begin
      if (!lk_open)     rd_next = FILL_BYTE;
      else if (hit_idx) rd_next = cur_idx;
      else if (glob_sel) rd_next = glob_rdata;
      else              rd_next = dev_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rvalid <= 1'b0;
         io_rdata  <= FILL_BYTE;
      end else begin
         io_rvalid <= any_rd;
         if (any_rd) io_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
   parameter int unsigned NUM_LD     = 8,
   parameter logic [7:0]  UNLOCK_KEY = 8'h87,
   parameter logic [7:0]  LOCK_KEY   = 8'hAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              io_rvalid,
   input logic [NUM_LD-1:0] ld_wr,
   input logic [NUM_LD-1:0] ld_rd,
   input logic              hit_idx,
   input logic              hit_dat,
   input logic              lk_open,
   input logic [7:0]        cur_idx,
   input logic [7:0]        cur_ldn
);
   // R13
   read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && (hit_idx || hit_dat)) |=> io_rvalid);
   // R13
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && (hit_idx || hit_dat)) |=> !io_rvalid);
   // R9
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_wr));
   // R10
   rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_rd));
   // R4
   locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_open |-> (ld_wr == '0 && ld_rd == '0));
   // R4
   locked_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_open && io_wr) |=> $stable(cur_ldn));
   // R3
   open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lk_open) |-> $past(io_wr && hit_idx && io_wdata == UNLOCK_KEY));
   // R5
   lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_open && io_wr && hit_idx && io_wdata == LOCK_KEY) |=> !lk_open);
   // R12
   global_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx < 8'h30) |-> (ld_wr == '0 && ld_rd == '0));
   // R2
   miss_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_idx || hit_dat) |-> (ld_wr == '0 && ld_rd == '0));
   // R1
   locked_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_open && io_rd && hit_dat) |=> io_rdata == 8'hFF);
endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(
   .NUM_LD(NUM_LD), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
) chk_i (
   .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
   .io_rdata(io_rdata), .io_rvalid(io_rvalid), .ld_wr(ld_wr), .ld_rd(ld_rd),
   .hit_idx(hit_idx), .hit_dat(hit_dat), .lk_open(lk_open),
   .cur_idx(cur_idx), .cur_ldn(cur_ldn)
);

// File: tb/cfgport_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfgport_ctrl_tb_top;
   localparam int NLD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_alt = 1'b0;
   logic [15:0] io_addr = '0;
   logic io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic io_rvalid;
   logic [7:0] ld_index, ld_wdata;
   logic [NLD-1:0] ld_wr, ld_rd;
   logic [NLD*8-1:0] ld_rdata;

   always #2.5 clk = ~clk;

   cfgport_ctrl #(.NUM_LD(NLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_rvalid(io_rvalid), .ld_index(ld_index), .ld_wdata(ld_wdata),
      .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
   );

   // device model: device k answers {k, low nibble of index}
   for (genvar k = 0; k < NLD; k++) begin : g_devm
      assign ld_rdata[k*8 +: 8] = {4'(k), ld_index[3:0]};
   end

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];
   string tag_q[$];
   logic [NLD-1:0] s_wr, s_rd;
   logic [7:0] s_idx, s_wd;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per returned read
   always @(negedge clk) begin
      if (rst_n && io_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R13: actual unexpected read %0h expected none", io_rdata);
         end else begin
            chk(tag_q.pop_front(), {24'h0, io_rdata}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic wr(logic [15:0] a, logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      #1;
      s_wr = ld_wr; s_rd = ld_rd; s_idx = ld_index; s_wd = ld_wdata;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
      io_addr = a; io_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      #1;
      s_wr = ld_wr; s_rd = ld_rd;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic rd_miss(logic [15:0] a, string tag);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      chk(tag, {31'h0, io_rvalid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rvalid after reset", {31'h0, io_rvalid}, 0);
      chk("R1 no strobes after reset", {24'h0, ld_wr, ld_rd}, 0);
      rd(16'h2F, 8'hFF, "R1 locked data read");
      rd(16'h2E, 8'hFF, "R1 locked index read");
      // R4 locked write ignored
      wr(16'h2F, 8'h03);
      chk("R4 locked write no strobe", {24'h0, s_wr, s_rd}, 0);
      // R3 broken key sequence
      wr(16'h2E, 8'h87); wr(16'h2E, 8'h55); wr(16'h2E, 8'h87);
      rd(16'h2F, 8'hFF, "R3 broken sequence stays locked");
      wr(16'h2E, 8'h87);
      rd(16'h2E, 8'h00, "R3 keys do not load index");
      // R7 selector, reset value
      wr(16'h2E, 8'h07);
      rd(16'h2E, 8'h07, "R6 index readback");
      rd(16'h2F, 8'h00, "R1 selector reset value");
      wr(16'h2F, 8'h06);
      chk("R12 selector write no strobe", {24'h0, s_wr, s_rd}, 0);
      rd(16'h2F, 8'h06, "R7 selector readback");
      // R8 identity
      wr(16'h2E, 8'h20); rd(16'h2F, 8'h08, "R8 chip id high");
      wr(16'h2E, 8'h21); rd(16'h2F, 8'h14, "R8 chip id low");
      wr(16'h2E, 8'h22); rd(16'h2F, 8'h05, "R8 revision");
      wr(16'h2E, 8'h23); wr(16'h2F, 8'h00);
      chk("R12 identity write no strobe", {24'h0, s_wr, s_rd}, 0);
      rd(16'h2F, 8'h19, "R8 vendor high read-only");
      wr(16'h2E, 8'h24); rd(16'h2F, 8'h34, "R8 vendor low");
      wr(16'h2E, 8'h2A); rd(16'h2F, 8'hFF, "R8 unimplemented global");
      // R9 / R10 forwarding to device 6
      wr(16'h2E, 8'h35);
      wr(16'h2F, 8'h5A);
      chk("R9 write strobe", {24'h0, s_wr}, 32'h40);
      chk("R9 index out", {24'h0, s_idx}, 32'h35);
      chk("R9 data out", {24'h0, s_wd}, 32'h5A);
      rd(16'h2F, 8'h65, "R10 device 6 read");
      chk("R10 read strobe", {24'h0, s_rd}, 32'h40);
      // R11 selector out of range
      wr(16'h2E, 8'h07); wr(16'h2F, 8'h09);
      wr(16'h2E, 8'hF0); wr(16'h2F, 8'h77);
      chk("R11 no write strobe", {24'h0, s_wr}, 0);
      rd(16'h2F, 8'hFF, "R11 out of range read");
      chk("R11 no read strobe", {24'h0, s_rd}, 0);
      // device 0
      wr(16'h2E, 8'h07); wr(16'h2F, 8'h00);
      wr(16'h2E, 8'hF3);
      rd(16'h2F, 8'h03, "R10 device 0 read");
      chk("R10 device 0 strobe", {24'h0, s_rd}, 32'h01);
      // R2 decode misses
      rd_miss(16'h4F, "R2 other base silent");
      wr(16'h4F, 8'h11);
      chk("R2 miss no strobe", {24'h0, s_wr, s_rd}, 0);
      rd_miss(16'h30, "R2 unrelated address silent");
      // R5 lock
      wr(16'h2E, 8'hAA);
      rd(16'h2F, 8'hFF, "R5 locked data read");
      rd(16'h2E, 8'hFF, "R5 locked index read");
      // R2 alternate base via strap
      strap_alt = 1'b1;
      wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
      rd(16'h4E, 8'hF3, "R5 index kept across lock");
      rd(16'h4F, 8'h03, "R2 alternate data port");
      rd_miss(16'h2F, "R2 old base silent");
      repeat (3) @(negedge clk);
      chk("R13 all reads returned", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule